// File: doc/BRIEF.md
# Floppy Controller Command Sequencer

This block models the host-facing protocol of a floppy disk controller. It has a byte-wide data port and a status byte. The host reads the status byte to see whose turn it is, then writes command and parameter bytes. The block runs a timed execution step and raises an interrupt. For commands that return a result, it offers result bytes for the host to read one at a time. It handles absolute seek, relative seek toward higher and lower cylinders, interrupt status sensing and head-position identification. It keeps a present-cylinder register for each of four drives.

It models no media, no data transfer and no DMA. The execution step is a fixed number of clock cycles, set by `EXEC_CYCLES`. A read is a one-cycle `dataRd` strobe that consumes the byte shown on `dataOut`. A write is a one-cycle `dataWr` strobe that carries `dataIn`.

Top module: `fdc_cmd_seq`

## Requirements
- R1: The status byte has three values. In command phase it is 0x80 (bit 7, ready). In execution phase it is 0x10 (bit 4, busy). In result phase it is 0xD0 (ready, bit 6 controller-to-host, busy). After reset the status byte is 0x80, `irq` is 0 and `dataOut` is 0x00.
- R2: The first byte is the opcode. 0x0F, 0xCF and 0x8F are absolute seek, relative seek up and relative seek down, each three bytes long. 0x0A is read ID, two bytes long. 0x08 is sense interrupt, one byte long. Byte 1 carries the head in bit 2 and the drive in bits 1:0. Byte 2 of a seek carries the target cylinder or the step count.
- R3: After the final byte of a seek or read ID, the status byte reads 0x10 for exactly `EXEC_CYCLES` cycles, starting in the next cycle.
- R4: Accepting a seek or read ID opcode clears any pending interrupt, and `irq` stays low while the parameter bytes and the execution step run. When a seek's execution ends, the drive's cylinder is updated and `irq` rises. The status byte then returns to 0x80 with no result phase.
- R5: A relative seek up adds the step to the drive's cylinder and a relative seek down subtracts it, both modulo 256.
- R6: A sense interrupt with `irq` high returns two bytes and drops `irq` in the cycle after the opcode. The first byte is 0x20 | head<<2 | drive of the last completed seek. The second is that drive's cylinder. With `irq` low it returns the single byte 0x80.
- R7: Read ID returns seven bytes: head<<2 | drive, 0x00, 0x00, the drive's cylinder, the head, 0x01 and 0x02. `irq` rises when the result phase starts and stays high until the last byte is read, then drops.
- R8: Once the last result byte is read, the status byte is 0x80.
- R9: An unknown opcode produces a result phase holding the single byte 0x80, and `irq` stays unchanged.
- R10: Writes during execution or result phase are ignored. Reads outside result phase return 0x00 and change nothing, including a pending `irq`. In result phase, `dataOut` holds steady until it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dataWr | input | 1 | Write strobe for the data port |
| dataIn | input | 8 | Byte written by the host |
| dataRd | input | 1 | Read strobe; consumes the current result byte |
| dataOut | output | 8 | Current result byte, 0x00 outside result phase |
| status | output | 8 | Status byte (ready, direction, busy) |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the following corner cases:
- Sense with and without a pending interrupt. A design that confused the two would return the wrong byte count or leave `irq` stuck high.
- Relative seeks that wrap past cylinder 0 and 255. A saturating or sign-confused adder would report the wrong cylinder.
- Read ID whose interrupt must survive six reads and fall on the seventh. Dropping it early, or never, would show at the port.
- Stray writes injected during execution and result phases, and reads in command phase. A design that accepted them would start a new command, cut the execution step short or lose a pending interrupt.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;
  localparam int DRV_BITS   = 2;
  localparam int NUM_DRIVES = 1 << DRV_BITS;

  localparam logic [7:0] OP_SEEK  = 8'h0F;
  localparam logic [7:0] OP_RIN   = 8'hCF;
  localparam logic [7:0] OP_ROUT  = 8'h8F;
  localparam logic [7:0] OP_SENSE = 8'h08;
  localparam logic [7:0] OP_RDID  = 8'h0A;

  localparam logic [7:0] ST_CMD   = 8'h80;
  localparam logic [7:0] ST_EXEC  = 8'h10;
  localparam logic [7:0] ST_RES   = 8'hD0;
  localparam logic [7:0] BYTE_BAD = 8'h80;
  localparam logic [7:0] SEEK_END = 8'h20;

  localparam logic [2:0] RDID_LAST = 3'd6;

  typedef enum logic [1:0] {PH_CMD, PH_EXEC, PH_RES} phase_t;
  typedef enum logic [2:0] {K_SEEK, K_RIN, K_ROUT, K_SENSE, K_RDID, K_BAD} kind_t;
  typedef enum logic [1:0] {RK_SINGLE, RK_SENSE, RK_RDID} resKind_t;

  typedef struct packed {
    logic capSel;
    logic capVal;
    logic applySeek;
  } dpStrobe_t;

  function automatic kind_t decodeOp(input logic [7:0] op);
    case (op)
      OP_SEEK:  return K_SEEK;
      OP_RIN:   return K_RIN;
      OP_ROUT:  return K_ROUT;
      OP_SENSE: return K_SENSE;
      OP_RDID:  return K_RDID;
      default:  return K_BAD;
    endcase
  endfunction
endpackage

// File: rtl/fdc_seq_ctrl.sv
module fdc_seq_ctrl
  import fdc_seq_pkg::*;
#(
  parameter int EXEC_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dataWr,
  input  logic [7:0] dataIn,
  input  logic       dataRd,
  output phase_t     phase,
  output kind_t      kind,
  output resKind_t   resKind,
  output logic [2:0] resIdx,
  output dpStrobe_t  stb,
  output logic       irq
);
  localparam int EXEC_W = $clog2(EXEC_CYCLES + 1);
  localparam logic [EXEC_W-1:0] EXEC_LAST = EXEC_W'(EXEC_CYCLES - 1);

  logic [1:0]        byteCnt;
  logic [EXEC_W-1:0] execCnt;
  logic [2:0]        resLast;
  kind_t             opKind;
  logic              acceptWr;
  logic              execDone;

  always_comb begin
    opKind        = decodeOp(dataIn);
    acceptWr      = dataWr && (phase == PH_CMD);
    execDone      = (phase == PH_EXEC) && (execCnt == EXEC_LAST);
    stb           = '0;
    stb.capSel    = acceptWr && (byteCnt == 2'd1);
    stb.capVal    = acceptWr && (byteCnt == 2'd2);
    stb.applySeek = execDone && (kind != K_RDID);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_CMD;
      kind    <= K_BAD;
      resKind <= RK_SINGLE;
      resIdx  <= '0;
      resLast <= '0;
      byteCnt <= '0;
      execCnt <= '0;
      irq     <= 1'b0;
    end else begin
      case (phase)
        PH_CMD: begin
          if (dataWr) begin
            case (byteCnt)
              2'd0: begin
                kind <= opKind;
                case (opKind)
                  K_SENSE: begin
                    phase  <= PH_RES;
                    resIdx <= '0;
                    if (irq) begin
                      resKind <= RK_SENSE;
                      resLast <= 3'd1;
                      irq     <= 1'b0;
                    end else begin
                      resKind <= RK_SINGLE;
                      resLast <= 3'd0;
                    end
                  end
                  K_BAD: begin
                    phase   <= PH_RES;
                    resIdx  <= '0;
                    resKind <= RK_SINGLE;
                    resLast <= 3'd0;
                  end
                  default: begin
                    byteCnt <= 2'd1;
                    irq     <= 1'b0;
                  end
                endcase
              end
              2'd1: begin
                if (kind == K_RDID) begin
                  phase   <= PH_EXEC;
                  execCnt <= '0;
                  byteCnt <= 2'd0;
                end else begin
                  byteCnt <= 2'd2;
                end
              end
              default: begin
                phase   <= PH_EXEC;
                execCnt <= '0;
                byteCnt <= 2'd0;
              end
            endcase
          end
        end
        PH_EXEC: begin
          if (execDone) begin
            irq <= 1'b1;
            if (kind == K_RDID) begin
              phase   <= PH_RES;
              resKind <= RK_RDID;
              resLast <= RDID_LAST;
              resIdx  <= '0;
            end else begin
              phase <= PH_CMD;
            end
          end else begin
            execCnt <= execCnt + 1'b1;
          end
        end
        PH_RES: begin
          if (dataRd) begin
            if (resIdx == resLast) begin
              phase  <= PH_CMD;
              resIdx <= '0;
              if (resKind == RK_RDID) irq <= 1'b0;
            end else begin
              resIdx <= resIdx + 1'b1;
            end
          end
        end
        default: phase <= PH_CMD;
      endcase
    end
  end
endmodule

// File: rtl/fdc_seq_dpath.sv
module fdc_seq_dpath
  import fdc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] dataIn,
  input  dpStrobe_t  stb,
  input  kind_t      kind,
  input  phase_t     phase,
  input  resKind_t   resKind,
  input  logic [2:0] resIdx,
  output logic [7:0] dataOut,
  output logic [7:0] status
);
  logic [2:0]          selReg;
  logic [7:0]          valReg;
  logic [DRV_BITS-1:0] lastDrv;
  logic                lastHead;
  logic [DRV_BITS-1:0] selDrv;
  logic                selHead;
  logic [7:0]          cylBank [NUM_DRIVES];
  logic [7:0]          nextCyl;
  logic [7:0]          resByte;

  assign selDrv  = selReg[DRV_BITS-1:0];
  assign selHead = selReg[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selReg   <= '0;
      valReg   <= '0;
      lastDrv  <= '0;
      lastHead <= 1'b0;
    end else begin
      if (stb.capSel) selReg <= dataIn[2:0];
      if (stb.capVal) valReg <= dataIn;
      if (stb.applySeek) begin
        lastDrv  <= selDrv;
        lastHead <= selHead;
      end
    end
  end

  always_comb begin
    case (kind)
      K_RIN:   nextCyl = cylBank[selDrv] + valReg;
      K_ROUT:  nextCyl = cylBank[selDrv] - valReg;
      default: nextCyl = valReg;
    endcase
  end

  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drv
    logic [7:0] cylQ;
    always_ff @(posedge clk) begin
      if (!rst_n) cylQ <= '0;
      else if (stb.applySeek && (selDrv == DRV_BITS'(g))) cylQ <= nextCyl;
    end
    assign cylBank[g] = cylQ;
  end

  always_comb begin
    case (resKind)
      RK_SENSE:
        resByte = (resIdx == 3'd0) ? (SEEK_END | {5'b0, lastHead, lastDrv}) : cylBank[lastDrv];
      RK_RDID: begin
        case (resIdx)
          3'd0:    resByte = {5'b0, selHead, selDrv};
          3'd3:    resByte = cylBank[selDrv];
          3'd4:    resByte = {7'b0, selHead};
          3'd5:    resByte = 8'h01;
          3'd6:    resByte = 8'h02;
          default: resByte = 8'h00;
        endcase
      end
      default: resByte = BYTE_BAD;
    endcase
  end

  always_comb begin
    case (phase)
      PH_EXEC: status = ST_EXEC;
      PH_RES:  status = ST_RES;
      default: status = ST_CMD;
    endcase
    dataOut = (phase == PH_RES) ? resByte : 8'h00;
  end
endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
  import fdc_seq_pkg::*;
#(
  parameter int EXEC_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dataWr,
  input  logic [7:0] dataIn,
  input  logic       dataRd,
  output logic [7:0] dataOut,
  output logic [7:0] status,
  output logic       irq
);
  phase_t     phase;
  kind_t      kind;
  resKind_t   resKind;
  logic [2:0] resIdx;
  dpStrobe_t  stb;

  fdc_seq_ctrl #(.EXEC_CYCLES(EXEC_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .dataWr(dataWr), .dataIn(dataIn), .dataRd(dataRd),
    .phase(phase), .kind(kind), .resKind(resKind), .resIdx(resIdx), .stb(stb), .irq(irq)
  );

  fdc_seq_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .dataIn(dataIn), .stb(stb), .kind(kind), .phase(phase),
    .resKind(resKind), .resIdx(resIdx), .dataOut(dataOut), .status(status)
  );
endmodule

// File: rtl/fdc_cmd_seq_chk.sv
module fdc_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dataWr,
  input logic [7:0] dataIn,
  input logic       dataRd,
  input logic [7:0] dataOut,
  input logic [7:0] status,
  input logic       irq
);
  p_status_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 8'h80) || (status == 8'h10) || (status == 8'hD0));

  p_seek_op_clears_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 8'h80 && dataWr && dataIn == 8'h0F) |=> !irq);

  p_irq_rise_after_exec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(status) == 8'h10));

  p_rdid_irq_on_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status) == 8'h10 && status == 8'hD0) |-> irq);

  p_back_to_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status == 8'hD0) |-> (status == 8'h80));

  p_idle_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 8'hD0) |-> (dataOut == 8'h00));

  p_res_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 8'hD0 && !dataRd) |=> (status == 8'hD0) && $stable(dataOut));
endmodule

bind fdc_cmd_seq fdc_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dataWr(dataWr), .dataIn(dataIn), .dataRd(dataRd),
  .dataOut(dataOut), .status(status), .irq(irq)
);

// File: tb/sim_fdc_cmd_seq.sv
module sim_fdc_cmd_seq;
  localparam int EXEC = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dataWr = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic       dataRd = 1'b0;
  logic [7:0] dataOut;
  logic [7:0] status;
  logic       irq;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  logic [7:0] cylModel [4];
  logic [1:0] lastDrv = 2'd0;
  logic       lastHead = 1'b0;

  fdc_cmd_seq #(.EXEC_CYCLES(EXEC)) u0 (
    .clk(clk), .rst_n(rst_n), .dataWr(dataWr), .dataIn(dataIn), .dataRd(dataRd),
    .dataOut(dataOut), .status(status), .irq(irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nFails = nFails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  function automatic logic [7:0] senseSt0(input logic head, input logic [1:0] drv);
    return 8'h20 | {5'b0, head, drv};
  endfunction

  function automatic logic [7:0] rdidByte(input int i, input logic head, input logic [1:0] drv,
                                          input logic [7:0] cyl);
    case (i)
      0: return {5'b0, head, drv};
      3: return cyl;
      4: return {7'b0, head};
      5: return 8'h01;
      6: return 8'h02;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks = nChecks + 1;
    if (act !== exp) begin
      nFails = nFails + 1;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input string tag);
    @(negedge clk);
    chk(tag, status, 8'h80);
    dataWr = 1'b1;
    dataIn = b;
    @(negedge clk);
    dataWr = 1'b0;
  endtask

  task automatic recvByte(output logic [7:0] b, input string tag);
    @(negedge clk);
    chk(tag, status, 8'hD0);
    b = dataOut;
    dataRd = 1'b1;
    @(negedge clk);
    dataRd = 1'b0;
  endtask

  task automatic waitExec(inout int cnt);
    while (status == 8'h10 && cnt < 1000) begin
      cnt = cnt + 1;
      @(negedge clk);
    end
  endtask

  task automatic doSeek(input logic [7:0] op, input logic [1:0] drv, input logic head,
                        input logic [7:0] val, input bit poke);
    int cnt = 0;
    sendByte(op, "R2 opcode");
    chk("R4 irq low after opcode", {7'b0, irq}, 8'h00);
    sendByte({5'b0, head, drv}, "R2 select");
    chk("R4 irq low after select", {7'b0, irq}, 8'h00);
    sendByte(val, "R2 value");
    chk("R3 busy after last byte", status, 8'h10);
    chk("R4 irq low in exec", {7'b0, irq}, 8'h00);
    if (poke) begin
      dataWr = 1'b1;
      dataIn = 8'h08;
      @(negedge clk);
      dataWr = 1'b0;
      cnt = 1;
    end
    waitExec(cnt);
    chk("R3 exec length", 8'(cnt), 8'(EXEC));
    chk("R4 status after seek", status, 8'h80);
    chk("R4 irq after seek", {7'b0, irq}, 8'h01);
    case (op)
      8'hCF:   cylModel[drv] = cylModel[drv] + val;
      8'h8F:   cylModel[drv] = cylModel[drv] - val;
      default: cylModel[drv] = val;
    endcase
    lastDrv = drv;
    lastHead = head;
  endtask

  task automatic doSense(input bit pending);
    logic [7:0] b;
    sendByte(8'h08, "R2 sense opcode");
    chk("R6 irq after sense", {7'b0, irq}, 8'h00);
    if (pending) begin
      recvByte(b, "R6 st0 status");
      chk("R6 st0", b, senseSt0(lastHead, lastDrv));
      recvByte(b, "R6 cyl status");
      chk("R6 cylinder", b, cylModel[lastDrv]);
    end else begin
      recvByte(b, "R6 none status");
      chk("R6 no pending byte", b, 8'h80);
    end
    chk("R8 back to command", status, 8'h80);
  endtask

  task automatic doReadId(input logic [1:0] drv, input logic head, input bit poke);
    logic [7:0] b;
    int cnt = 0;
    sendByte(8'h0A, "R2 read id opcode");
    sendByte({5'b0, head, drv}, "R2 read id select");
    chk("R7 busy during exec", status, 8'h10);
    waitExec(cnt);
    chk("R3 read id exec length", 8'(cnt), 8'(EXEC));
    chk("R7 result status", status, 8'hD0);
    chk("R7 irq at result", {7'b0, irq}, 8'h01);
    for (int i = 0; i < 7; i++) begin
      recvByte(b, "R7 byte status");
      chk($sformatf("R7 byte %0d", i), b, rdidByte(i, head, drv, cylModel[drv]));
      chk("R7 irq while reading", {7'b0, irq}, (i < 6) ? 8'h01 : 8'h00);
      if (poke && i == 0) begin
        dataWr = 1'b1;
        dataIn = 8'h0F;
        @(negedge clk);
        dataWr = 1'b0;
        chk("R10 write in result ignored", status, 8'hD0);
      end
    end
    chk("R8 back to command", status, 8'h80);
  endtask

  initial begin
    logic [7:0] b;
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) cylModel[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", status, 8'h80);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
    chk("R1 reset data", dataOut, 8'h00);

    doSense(1'b0);

    sendByte(8'h55, "R9 opcode");
    chk("R9 irq unchanged", {7'b0, irq}, 8'h00);
    recvByte(b, "R9 result status");
    chk("R9 invalid byte", b, 8'h80);
    chk("R8 after invalid", status, 8'h80);

    doSeek(8'h0F, 2'd0, 1'b0, 8'd0, 1'b0);
    doSense(1'b1);
    doSeek(8'hCF, 2'd0, 1'b0, 8'd1, 1'b0);
    doSense(1'b1);
    chk("R5 up by one", cylModel[0], 8'd1);
    doSeek(8'h8F, 2'd0, 1'b0, 8'd1, 1'b0);
    doSense(1'b1);

    doSeek(8'h8F, 2'd2, 1'b1, 8'd5, 1'b0);
    doSense(1'b1);
    doSeek(8'hCF, 2'd2, 1'b1, 8'd10, 1'b0);
    doSense(1'b1);

    doSeek(8'h0F, 2'd1, 1'b1, 8'd8, 1'b0);
    @(negedge clk);
    dataRd = 1'b1;
    chk("R10 idle read zero", dataOut, 8'h00);
    @(negedge clk);
    dataRd = 1'b0;
    chk("R10 idle read status", status, 8'h80);
    chk("R10 idle read keeps irq", {7'b0, irq}, 8'h01);
    doSense(1'b1);
    doReadId(2'd1, 1'b1, 1'b0);
    doReadId(2'd0, 1'b0, 1'b1);

    doSeek(8'h0F, 2'd3, 1'b0, 8'd77, 1'b1);
    doSense(1'b1);

    doSeek(8'h0F, 2'd1, 1'b0, 8'd20, 1'b0);
    doSeek(8'hCF, 2'd1, 1'b0, 8'd3, 1'b0);
    doSense(1'b1);

    for (int it = 0; it < 40; it++) begin
      int sel = $urandom % 4;
      logic [1:0] d = 2'($urandom % 4);
      logic h = 1'($urandom % 2);
      logic [7:0] v = 8'($urandom % 256);
      case (sel)
        0: begin doSeek(8'h0F, d, h, v, 1'b0); doSense(1'b1); end
        1: begin doSeek(8'hCF, d, h, v, 1'b0); doSense(1'b1); end
        2: begin doSeek(8'h8F, d, h, v, 1'b0); doSense(1'b1); end
        default: doReadId(d, h, 1'b0);
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule